// File: doc/BRIEF.md
# Code density linearity analyzer

This block measures the static linearity of an analog-to-digital converter from its own output stream. A slow ramp sweeps the converter's input across full scale some number of times (typically 64, 128 or 256 sweeps), so that every input step is equally likely. The block counts how often each output code appears, with one saturating counter per code in on-chip memory. When the run is declared complete, it works out each code's differential nonlinearity (DNL) and integral nonlinearity (INL) relative to the mean occupancy of the interior codes. It then streams the results out one code at a time, in ascending order.

The code width is a parameter. Set `CODE_W` to 14 for a 14-bit converter (16384 bins). Each DNL is found by a bit-serial fixed-point divide: the bin count, times the number of interior codes, shifted by the fraction width, divided by the interior total. One is then subtracted from the quotient. Results are signed Q8.16 in LSB, clamped to the 24-bit range. INL is the running sum of DNL. The two end codes report zero for both measures and do not count toward the mean.

States:
- `ST_IDLE`: after reset.
- `ST_CLEAR`: sweeps every bin to zero.
- `ST_ACCUM`: counts samples.
- `ST_DRAIN`: lets the last increment land.
- `ST_SUM` and `ST_SUM_LAST`: add up the interior bins.
- `ST_CHECK`: tests the total.
- `ST_FETCH`, `ST_LOAD`, `ST_DIVIDE` and `ST_EMIT`: produce one result per code.
- `ST_DONE` and `ST_FAULT`: terminal states.

Transitions:
- clear command: from `ST_IDLE`, `ST_ACCUM`, `ST_DONE` or `ST_FAULT` into `ST_CLEAR`.
- sweep end: `ST_CLEAR` to `ST_ACCUM`.
- finish command: `ST_ACCUM` to `ST_DRAIN`.
- scan end: `ST_SUM` to `ST_SUM_LAST`.
- zero total: `ST_CHECK` to `ST_FAULT`.
- nonzero total: `ST_CHECK` to `ST_FETCH`.
- end-code bypass: `ST_LOAD` to `ST_EMIT`.
- divide done: `ST_DIVIDE` to `ST_EMIT`.
- next code: `ST_EMIT` to `ST_FETCH`.
- last code: `ST_EMIT` to `ST_DONE`.

Top module: `cdl_linearity_analyzer`

## Requirements
- R1: After reset `busy`, `res_valid`, `res_done` and `res_err` are low. A `cmd_clear` seen while `busy` is low zeroes all 2^CODE_W bins. `busy` is then high for exactly 2^CODE_W cycles, starting in the cycle after the command. Samples offered while it is high are not counted.
- R2: Once the clear ends, each cycle with `smp_valid` high adds one to the bin of `smp_code`. This includes runs of the same code on consecutive cycles.
- R3: A bin holds at 2^CNT_W-1 instead of wrapping.
- R4: A sample offered in the same cycle as `cmd_finish` is counted. A sample offered in the same cycle as `cmd_clear` is discarded.
- R5: The mean is taken over codes 1 to 2^CODE_W-2 only. The counts in code 0 and code 2^CODE_W-1 do not change any result.
- R6: For an interior code n, `res_dnl` equals floor(count(n)*(2^CODE_W-2)*2^16/T) - 2^16. Here T is the interior total. The value is two's complement, with 16 fraction bits.
- R7: Codes 0 and 2^CODE_W-1 report `res_dnl` = 0 and `res_inl` = 0.
- R8: For interior codes, `res_inl` equals the previous code's INL plus this code's `res_dnl`, starting from 0 at code 0.
- R9: Results arrive as one single-cycle `res_valid` pulse per code, with `res_code` ascending from 0 to 2^CODE_W-1. There are never two pulses in consecutive cycles.
- R10: After the last code, `res_done` is high and `busy` is low until the next clear. `res_done` rises only in the cycle after the last code's pulse.
- R11: If T is zero, `res_err` goes high, `busy` falls and no result is emitted.
- R12: `cmd_finish` outside accumulation produces no result and leaves the flags unchanged. Samples offered during the scan and readout do not alter any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Converter output code |
| cmd_clear | input | 1 | Zero the histogram and start a run |
| cmd_finish | input | 1 | End the run and compute results |
| busy | output | 1 | Clearing, scanning or reading out |
| res_valid | output | 1 | Result strobe, one per code |
| res_code | output | CODE_W | Code of the current result |
| res_dnl | output | OUT_W | DNL, signed, 16 fraction bits |
| res_inl | output | OUT_W | INL, signed, 16 fraction bits |
| res_done | output | 1 | All codes reported |
| res_err | output | 1 | Interior total was zero |

## Verification
Two pairs of events can collide in one cycle: a sample strobe with the finish command, and a sample strobe with the clear command. The first must be counted and the second dropped. The bench drives each pair together, then reads the histogram back through the computed DNL. It omits code 6 from a ramp so that a wrongly counted coincident sample shows up as a nonzero count. A related overlap is a same-code increment landing while the next read of that bin starts. This is provoked with long runs of one code and judged against counts the bench keeps itself.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ACCUM,
        ST_DRAIN,
        ST_SUM,
        ST_SUM_LAST,
        ST_CHECK,
        ST_FETCH,
        ST_LOAD,
        ST_DIVIDE,
        ST_EMIT,
        ST_DONE,
        ST_FAULT
    } cdl_state_e;

endpackage

// File: rtl/cdl_bin_ram.sv
module cdl_bin_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // read returns the value held before a write at the same edge
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cdl_bin_inc.sv
module cdl_bin_inc #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_code,
    input  logic [CNT_W-1:0]  rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CNT_W-1:0]  wr_data
);
    logic              s_valid;
    logic [ADDR_W-1:0] s_code;
    logic              f_valid;
    logic [ADDR_W-1:0] f_addr;
    logic [CNT_W-1:0]  f_val;
    logic [CNT_W-1:0]  cur;
    logic [CNT_W-1:0]  nxt;

    // a write at the previous edge is not yet visible in rd_data
    always_comb begin
        cur     = (f_valid && (f_addr == s_code)) ? f_val : rd_data;
        nxt     = (&cur) ? cur : cur + CNT_W'(1);
        wr_en   = s_valid;
        wr_addr = s_code;
        wr_data = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_code  <= '0;
            f_valid <= 1'b0;
            f_addr  <= '0;
            f_val   <= '0;
        end else begin
            s_valid <= in_valid;
            s_code  <= in_code;
            f_valid <= s_valid;
            f_addr  <= s_code;
            f_val   <= nxt;
        end
    end
endmodule

// File: rtl/cdl_seq_div.sv
module cdl_seq_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int SW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [NUM_W-1:0] nsh;
    logic [SW-1:0]    step;
    logic             run;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {rem, nsh[NUM_W-1]};
        diff  = trial - {1'b0, den};
        fits  = (trial >= {1'b0, den});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            nsh  <= '0;
            step <= '0;
            run  <= 1'b0;
            done <= 1'b0;
            quo  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= '0;
                nsh  <= num;
                step <= '0;
                run  <= 1'b1;
            end else if (run) begin
                rem  <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                nsh  <= nsh << 1;
                quo  <= {quo[NUM_W-2:0], fits};
                step <= step + SW'(1);
                if (step == SW'(NUM_W - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cdl_linearity_analyzer.sv
module cdl_linearity_analyzer
    import cdl_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int CNT_W  = 24,
    parameter int FRAC_W = 16,
    parameter int OUT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              cmd_clear,
    input  logic              cmd_finish,
    output logic              busy,
    output logic              res_valid,
    output logic [CODE_W-1:0] res_code,
    output logic [OUT_W-1:0]  res_dnl,
    output logic [OUT_W-1:0]  res_inl,
    output logic              res_done,
    output logic              res_err
);
    localparam int NBINS = 1 << CODE_W;
    localparam int TOT_W = CNT_W + CODE_W;
    localparam int NUM_W = TOT_W + FRAC_W;
    localparam int DW    = NUM_W + 2;
    localparam int ACC_W = OUT_W + CODE_W + 1;

    localparam logic [CODE_W-1:0] LAST   = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] PENULT = LAST - CODE_W'(1);
    localparam logic [TOT_W-1:0]  INNER  = TOT_W'(NBINS - 2);

    localparam logic signed [DW-1:0] ONE_D =
        {{(DW-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
    localparam logic signed [DW-1:0] DMAX =
        {{(DW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [DW-1:0] DMIN =
        {{(DW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] AMAX =
        {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] AMIN =
        {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    cdl_state_e st;
    cdl_state_e st_nx;

    logic [CODE_W-1:0]       idx;
    logic [TOT_W-1:0]        total;
    logic                    pend;
    logic signed [ACC_W-1:0] inl_acc;

    logic              ram_we;
    logic [CODE_W-1:0] ram_waddr;
    logic [CNT_W-1:0]  ram_wdata;
    logic [CODE_W-1:0] ram_raddr;
    logic [CNT_W-1:0]  ram_rdata;

    logic              inc_valid;
    logic              inc_we;
    logic [CODE_W-1:0] inc_waddr;
    logic [CNT_W-1:0]  inc_wdata;

    logic              div_start;
    logic              div_done;
    logic [TOT_W-1:0]  prod;
    logic [NUM_W-1:0]  div_num;
    logic [NUM_W-1:0]  div_quo;

    logic                    is_end;
    logic signed [DW-1:0]    dnl_wide;
    logic [OUT_W-1:0]        dnl_sat;
    logic signed [ACC_W-1:0] inl_sum;
    logic [OUT_W-1:0]        inl_sat;

    cdl_bin_ram #(.ADDR_W(CODE_W), .DATA_W(CNT_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    cdl_bin_inc #(.ADDR_W(CODE_W), .CNT_W(CNT_W)) u_inc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (inc_valid),
        .in_code  (smp_code),
        .rd_data  (ram_rdata),
        .wr_en    (inc_we),
        .wr_addr  (inc_waddr),
        .wr_data  (inc_wdata)
    );

    cdl_seq_div #(.NUM_W(NUM_W), .DEN_W(TOT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (total),
        .done  (div_done),
        .quo   (div_quo)
    );

    // memory port steering and per-code arithmetic
    always_comb begin
        inc_valid = smp_valid && (st == ST_ACCUM) && !cmd_clear;
        ram_raddr = (st == ST_ACCUM) ? smp_code : idx;
        if (st == ST_CLEAR) begin
            ram_we    = 1'b1;
            ram_waddr = idx;
            ram_wdata = '0;
        end else begin
            ram_we    = inc_we;
            ram_waddr = inc_waddr;
            ram_wdata = inc_wdata;
        end

        is_end    = (idx == '0) || (idx == LAST);
        prod      = TOT_W'(ram_rdata) * INNER;
        div_num   = {prod, {FRAC_W{1'b0}}};
        div_start = (st == ST_LOAD) && !is_end;

        dnl_wide = $signed({2'b00, div_quo}) - ONE_D;
        if (is_end) begin
            dnl_sat = '0;
        end else if (dnl_wide > DMAX) begin
            dnl_sat = DMAX[OUT_W-1:0];
        end else if (dnl_wide < DMIN) begin
            dnl_sat = DMIN[OUT_W-1:0];
        end else begin
            dnl_sat = dnl_wide[OUT_W-1:0];
        end

        inl_sum = inl_acc + {{(ACC_W-OUT_W){dnl_sat[OUT_W-1]}}, dnl_sat};
        if (is_end) begin
            inl_sat = '0;
        end else if (inl_sum > AMAX) begin
            inl_sat = AMAX[OUT_W-1:0];
        end else if (inl_sum < AMIN) begin
            inl_sat = AMIN[OUT_W-1:0];
        end else begin
            inl_sat = inl_sum[OUT_W-1:0];
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (cmd_clear) st_nx = ST_CLEAR;
            ST_CLEAR:    if (idx == LAST) st_nx = ST_ACCUM;
            ST_ACCUM: begin
                if (cmd_clear)       st_nx = ST_CLEAR;
                else if (cmd_finish) st_nx = ST_DRAIN;
            end
            ST_DRAIN:    st_nx = ST_SUM;
            ST_SUM:      if (idx == PENULT) st_nx = ST_SUM_LAST;
            ST_SUM_LAST: st_nx = ST_CHECK;
            ST_CHECK:    st_nx = (total == '0) ? ST_FAULT : ST_FETCH;
            ST_FETCH:    st_nx = ST_LOAD;
            ST_LOAD:     st_nx = is_end ? ST_EMIT : ST_DIVIDE;
            ST_DIVIDE:   if (div_done) st_nx = ST_EMIT;
            ST_EMIT:     st_nx = (idx == LAST) ? ST_DONE : ST_FETCH;
            ST_DONE:     if (cmd_clear) st_nx = ST_CLEAR;
            ST_FAULT:    if (cmd_clear) st_nx = ST_CLEAR;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // index, total and INL accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            total   <= '0;
            pend    <= 1'b0;
            inl_acc <= '0;
        end else begin
            pend <= (st == ST_SUM);
            if (pend) begin
                total <= total + TOT_W'(ram_rdata);
            end
            case (st)
                ST_IDLE, ST_ACCUM, ST_DONE, ST_FAULT: begin
                    if (st_nx == ST_CLEAR) idx <= '0;
                end
                ST_CLEAR: idx <= idx + CODE_W'(1);
                ST_DRAIN: begin
                    idx   <= CODE_W'(1);
                    total <= '0;
                end
                ST_SUM:   idx <= idx + CODE_W'(1);
                ST_CHECK: begin
                    idx     <= '0;
                    inl_acc <= '0;
                end
                ST_EMIT: begin
                    idx     <= idx + CODE_W'(1);
                    inl_acc <= inl_sum;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = !((st == ST_IDLE) || (st == ST_ACCUM) ||
                      (st == ST_DONE) || (st == ST_FAULT));
        res_valid = (st == ST_EMIT);
        res_code  = idx;
        res_dnl   = dnl_sat;
        res_inl   = inl_sat;
        res_done  = (st == ST_DONE);
        res_err   = (st == ST_FAULT);
    end
endmodule

// File: rtl/cdl_linearity_analyzer_chk.sv
module cdl_linearity_analyzer_chk #(
    parameter int CODE_W = 10,
    parameter int FRAC_W = 16,
    parameter int OUT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_clear,
    input logic              busy,
    input logic              res_valid,
    input logic [CODE_W-1:0] res_code,
    input logic [OUT_W-1:0]  res_dnl,
    input logic [OUT_W-1:0]  res_inl,
    input logic              res_done,
    input logic              res_err
);
    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};
    localparam logic signed [OUT_W-1:0] NEG_ONE =
        {{(OUT_W-FRAC_W){1'b1}}, {FRAC_W{1'b0}}};

    // R1
    clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !busy) |=> busy);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7
    end_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ((res_code == '0) || (res_code == TOP_CODE)))
        |-> ((res_dnl == '0) && (res_inl == '0)));

    // R6
    dnl_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($signed(res_dnl) >= NEG_ONE));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> (!busy && !res_valid && !res_err));

    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_done) |-> $past(res_valid && (res_code == TOP_CODE)));

    // R11
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> (!busy && !res_valid));
endmodule

bind cdl_linearity_analyzer cdl_linearity_analyzer_chk #(
    .CODE_W (CODE_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_clear (cmd_clear),
    .busy      (busy),
    .res_valid (res_valid),
    .res_code  (res_code),
    .res_dnl   (res_dnl),
    .res_inl   (res_inl),
    .res_done  (res_done),
    .res_err   (res_err)
);

// File: tb/cdl_linearity_analyzer_bench.sv
module cdl_linearity_analyzer_bench;
    localparam int CW = 4;
    localparam int NB = 16;
    localparam int KW = 8;
    localparam int FW = 16;
    localparam int OW = 24;
    localparam longint KMAX = 255;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          smp_valid;
    logic [CW-1:0] smp_code;
    logic          cmd_clear;
    logic          cmd_finish;
    logic          busy;
    logic          res_valid;
    logic [CW-1:0] res_code;
    logic [OW-1:0] res_dnl;
    logic [OW-1:0] res_inl;
    logic          res_done;
    logic          res_err;

    always #2 clk = ~clk;

    cdl_linearity_analyzer #(.CODE_W(CW), .CNT_W(KW), .FRAC_W(FW), .OUT_W(OW))
    u_cdl_linearity_analyzer (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .cmd_clear(cmd_clear), .cmd_finish(cmd_finish), .busy(busy),
        .res_valid(res_valid), .res_code(res_code), .res_dnl(res_dnl),
        .res_inl(res_inl), .res_done(res_done), .res_err(res_err)
    );

    int     checks = 0;
    int     fails  = 0;
    bit     finished = 0;
    longint ref_cnt [NB];
    longint exp_d [NB];
    logic [CW-1:0] got_code [NB];
    logic [OW-1:0] got_dnl [NB];
    logic [OW-1:0] got_inl [NB];
    int     got_n;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic longint sat_out(input longint v);
        longint hi = (longint'(1) <<< (OW - 1)) - 1;
        longint lo = -(longint'(1) <<< (OW - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic put(input int code);
        smp_valid = 1'b1;
        smp_code  = CW'(code);
        @(negedge clk);
        smp_valid = 1'b0;
        if (ref_cnt[code] < KMAX) ref_cnt[code]++;
    endtask

    // coincident >= 0 drives a sample together with the command (must be dropped)
    // inject >= 0 drives a sample in the last busy cycle of the sweep (must be dropped)
    task automatic do_clear(input int coincident, input int inject);
        int n;
        cmd_clear = 1'b1;
        smp_valid = (coincident >= 0);
        smp_code  = CW'(coincident);
        @(negedge clk);
        cmd_clear = 1'b0;
        smp_valid = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            smp_valid = (inject >= 0) && (n == NB);
            smp_code  = CW'(inject);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        chk("R1 busy cycles during clear", n, NB);
        foreach (ref_cnt[i]) ref_cnt[i] = 0;
    endtask

    task automatic finish_collect(input int coincident, input bit inject);
        int guard;
        cmd_finish = 1'b1;
        smp_valid  = (coincident >= 0);
        smp_code   = CW'(coincident);
        if (coincident >= 0 && ref_cnt[coincident] < KMAX) ref_cnt[coincident]++;
        @(negedge clk);
        cmd_finish = 1'b0;
        smp_valid  = 1'b0;
        got_n = 0;
        guard = 0;
        while (!res_done && !res_err && guard < 5000) begin
            if (res_valid) begin
                if (got_n < NB) begin
                    got_code[got_n] = res_code;
                    got_dnl[got_n]  = res_dnl;
                    got_inl[got_n]  = res_inl;
                end
                got_n++;
            end
            smp_valid = inject && (got_n == 3);
            smp_code  = CW'(14);
            @(negedge clk);
            guard++;
        end
        smp_valid = 1'b0;
    endtask

    task automatic check_results(input string dreq);
        longint total = 0;
        longint acc = 0;
        longint q, d, i;
        for (int n = 1; n < NB - 1; n++) total += ref_cnt[n];
        chk("R9 result count", got_n, NB);
        for (int n = 0; n < NB; n++) begin
            if (n == 0 || n == NB - 1) begin
                d = 0;
                i = 0;
            end else begin
                q = ((ref_cnt[n] * (NB - 2)) <<< FW) / total;
                d = sat_out(q - (longint'(1) <<< FW));
                acc += d;
                i = sat_out(acc);
            end
            exp_d[n] = d;
            chk("R9 code order", longint'(got_code[n]), n);
            if (n == 0 || n == NB - 1) begin
                chk("R7 end code DNL", longint'($signed(got_dnl[n])), 0);
                chk("R7 end code INL", longint'($signed(got_inl[n])), 0);
            end else begin
                chk(dreq, longint'($signed(got_dnl[n])), d);
                chk("R8 INL running sum", longint'($signed(got_inl[n])), i);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        int seen;
        rst_n = 1'b0;
        smp_valid = 1'b0;
        smp_code = '0;
        cmd_clear = 1'b0;
        cmd_finish = 1'b0;
        foreach (ref_cnt[i]) ref_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy after reset", busy, 0);
        chk("R1 res_valid after reset", res_valid, 0);
        chk("R1 res_done after reset", res_done, 0);
        chk("R1 res_err after reset", res_err, 0);

        // uniform ramp, four sweeps: all zero. Sample in last clear cycle must be dropped.
        do_clear(-1, 1);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < NB; c++) put(c);
        finish_collect(-1, 1'b1); // R12 samples injected during readout
        check_results("R6 uniform DNL");
        chk("R10 done after readout", res_done, 1);
        chk("R10 busy low when done", busy, 0);
        // R12 finish while done: no new results
        cmd_finish = 1'b1;
        @(negedge clk);
        cmd_finish = 1'b0;
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            if (res_valid) seen++;
            @(negedge clk);
        end
        chk("R12 no result on finish outside run", seen, 0);
        chk("R12 done held", res_done, 1);

        // R2 grouped same-code bursts plus interleaved passes; R5 heavy end bins; R4 finish coincident
        do_clear(-1, -1);
        for (int c = 0; c < NB; c++) begin
            int cnt;
            if (c == 0 || c == NB - 1) cnt = 40;
            else if (c == 3) cnt = 0;
            else if (c == 9) cnt = 30;
            else cnt = (c * 5) % 7 + 1;
            for (int k = 0; k < cnt; k++) put(c);
        end
        for (int r = 0; r < 3; r++)
            for (int c = 1; c < NB - 1; c++) if (c != 3) put(c);
        finish_collect(7, 1'b0);
        check_results("R2 DNL after bursts");
        chk("R5 end bins excluded from mean", longint'($signed(got_dnl[4])), exp_d[4]);
        chk("R4 finish-coincident sample counted", longint'($signed(got_dnl[7])), exp_d[7]);

        // R4 clear-coincident sample dropped
        do_clear(-1, -1);
        for (int k = 0; k < 10; k++) put(5);
        do_clear(6, -1);
        for (int c = 0; c < NB; c++) if (c != 6) put(c);
        for (int c = 1; c < NB - 1; c++) if (c != 6) put(c);
        finish_collect(-1, 1'b0);
        check_results("R4 DNL after coincident clear");

        // R3 saturation
        do_clear(-1, -1);
        for (int k = 0; k < 300; k++) put(5);
        for (int c = 0; c < NB; c++) put(c);
        finish_collect(-1, 1'b0);
        check_results("R3 DNL with saturated bin");

        // R11 zero interior total
        do_clear(-1, -1);
        for (int k = 0; k < 5; k++) begin
            put(0);
            put(NB - 1);
        end
        finish_collect(-1, 1'b0);
        chk("R11 error flag", res_err, 1);
        chk("R11 no results", got_n, 0);
        chk("R11 busy low", busy, 0);
        chk("R11 done low", res_done, 0);
        do_clear(-1, -1); // R1 clear accepted from fault

        summary();
    end
endmodule